// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a record of why the system last came out of reset, so that boot software can choose a recovery path. Each reset source delivers a one-cycle pulse. The block turns the pulses into sticky flag bits in one 8-bit read-only register on the processor bus. A power-on event loads a fixed pattern in which only the power-on flag is set. Every other source sets only its own flag. Flags from several sources build up until software reads the register.

The read is destructive. The value returned is captured in a register on the read cycle and shows the flags as they stood just before the clear. The flags are then zeroed. Two sources are qualified. The illegal-address source counts only when the faulting access was an opcode fetch. The monitor-entry source counts only when the reset vector bytes are blank.

Top module: `rst_cause_reg`

## Requirements
- R1: After the synchronous reset, or after a power-on event pulse, the first read at address 0xFE01 returns 0x80 (bit 7 = power-on flag).
- R2: Only a read strobe at address 0xFE01 reads or clears the register. A read at any other address leaves both the flags and `rd_data` unchanged.
- R3: A read at 0xFE01 clears every flag, so a second read with no event in between returns 0x00.
- R4: Each source sets one flag: external pin sets bit 6, watchdog sets bit 5, illegal opcode sets bit 4, illegal-address fetch sets bit 3, monitor entry sets bit 2, low voltage sets bit 1.
- R5: The illegal-address pulse sets bit 3 only when `evt_addr_fetch` is high in the same cycle. A data access (`evt_addr_fetch` low) leaves the flags unchanged.
- R6: The monitor-entry pulse sets bit 2 only when `evt_vec_blank` is high in the same cycle.
- R7: A non-power-on event leaves all other flags as they were, so flags from separate cycles and from the same cycle accumulate.
- R8: A power-on event loads 0x80. This overrides any other event and any read in the same cycle.
- R9: When an event and a read at 0xFE01 fall in the same cycle, the read returns the flags without the new bit, and the new bit stays set afterwards.
- R10: A write strobe to 0xFE01 has no effect on the flags, whatever the write data.
- R11: Bit 0 of `rd_data` always reads 0.
- R12: `rd_data` is registered. It changes only on the cycle after a read at 0xFE01 and shows the flags held before that read's clear. It holds that value until the next such read, and it is 0x00 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pwr_on | input | 1 | Power-on reset event pulse |
| evt_pin | input | 1 | External reset pin event pulse |
| evt_wdog | input | 1 | Watchdog timeout event pulse |
| evt_bad_op | input | 1 | Illegal opcode event pulse |
| evt_bad_addr | input | 1 | Illegal address access event pulse |
| evt_addr_fetch | input | 1 | High when the illegal access was an opcode fetch |
| evt_mon_entry | input | 1 | Monitor-mode entry event pulse |
| evt_vec_blank | input | 1 | High when both reset vector bytes read 0xFF |
| evt_low_volt | input | 1 | Low-voltage inhibit event pulse |
| bus_addr | input | 16 | Bus address |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_wdata | input | 8 | Bus write data |
| rd_data | output | 8 | Registered read data |

## Verification
The embedded properties check the following on every cycle:
- the power-on override;
- the clear that follows a read, when no event is present;
- an event winning over a read in the same cycle;
- flags never being lost between reads;
- the captured read value and its holding between reads;
- a constant-zero bit 0;
- immunity to writes and to non-fetch illegal-address pulses.

Other behaviour needs the bench's scenarios. The exact bit that each source sets, the monitor-entry qualification, the address decode against near-miss addresses, and the values software sees across sequences of events and reads can only be shown there.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    localparam int DATA_W = 8;

    // Flag positions; software decodes these, so the order is fixed.
    localparam int POS_PWRON   = 7;
    localparam int POS_PIN     = 6;
    localparam int POS_WDOG    = 5;
    localparam int POS_BADOP   = 4;
    localparam int POS_BADADDR = 3;
    localparam int POS_MONITOR = 2;
    localparam int POS_LOWVOLT = 1;
    localparam int POS_UNUSED  = 0;

    localparam logic [DATA_W-1:0] PWRON_VALUE = DATA_W'(1) << POS_PWRON;

    typedef struct packed {
        logic pwr_on;
        logic pin;
        logic wdog;
        logic bad_op;
        logic bad_addr;
        logic addr_fetch;
        logic mon_entry;
        logic vec_blank;
        logic low_volt;
    } rst_evt_t;

    typedef struct packed {
        logic rd_hit;
        logic wr_hit;
    } bus_hit_t;

    // Set mask for the sticky (non power-on) flags, qualifiers applied.
    function automatic logic [DATA_W-1:0] cause_mask(input rst_evt_t e);
        logic [DATA_W-1:0] m;
        m = '0;
        m[POS_PIN]     = e.pin;
        m[POS_WDOG]    = e.wdog;
        m[POS_BADOP]   = e.bad_op;
        m[POS_BADADDR] = e.bad_addr & e.addr_fetch;
        m[POS_MONITOR] = e.mon_entry & e.vec_blank;
        m[POS_LOWVOLT] = e.low_volt;
        return m;
    endfunction

endpackage

// File: rtl/rcs_bus_decode.sv
module rcs_bus_decode
    import rcs_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFE01
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output bus_hit_t          hit
);
    logic addr_match;

    assign addr_match = (bus_addr == REG_ADDR);
    assign hit.rd_hit = bus_rd & addr_match;
    assign hit.wr_hit = bus_wr & addr_match;
endmodule

// File: rtl/rcs_event_qual.sv
module rcs_event_qual
    import rcs_pkg::*;
(
    input  rst_evt_t          evt,
    output logic              pwr_on,
    output logic [DATA_W-1:0] set_mask
);
    assign pwr_on   = evt.pwr_on;
    assign set_mask = cause_mask(evt);
endmodule

// File: rtl/rcs_cause_latch.sv
module rcs_cause_latch
    import rcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_on,
    input  logic [DATA_W-1:0] set_mask,
    input  logic              rd_hit,
    output logic [DATA_W-1:0] flags
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_flag
        if (b == POS_UNUSED) begin : g_tie
            assign flags[b] = 1'b0;
        end else if (b == POS_PWRON) begin : g_pwron
            logic q;
            always_ff @(posedge clk) begin
                if (rst || pwr_on) q <= 1'b1;
                else if (rd_hit)   q <= 1'b0;
            end
            assign flags[b] = q;
        end else begin : g_sticky
            logic q;
            always_ff @(posedge clk) begin
                if (rst || pwr_on)    q <= 1'b0;
                else if (set_mask[b]) q <= 1'b1;
                else if (rd_hit)      q <= 1'b0;
            end
            assign flags[b] = q;
        end
    end

    AST_PWRON_LOAD: assert property (@(posedge clk) disable iff (rst)
        pwr_on |=> (flags == PWRON_VALUE)); // R8

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && !pwr_on && set_mask == '0) |=> (flags == '0)); // R3

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && !pwr_on && set_mask != '0)
        |=> ((flags & $past(set_mask)) == $past(set_mask))); // R9

    AST_FLAGS_KEPT: assert property (@(posedge clk) disable iff (rst)
        (!rd_hit && !pwr_on) |=> ((flags & $past(flags)) == $past(flags))); // R7
endmodule

// File: rtl/rcs_read_port.sv
module rcs_read_port
    import rcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_hit,
    input  logic [DATA_W-1:0] flags,
    output logic [DATA_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst)         rd_data <= '0;
        else if (rd_hit) rd_data <= flags;
    end

    AST_RD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        rd_hit |=> (rd_data == $past(flags))); // R12

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_hit |=> $stable(rd_data)); // R12

    AST_BIT0_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_data[POS_UNUSED] == 1'b0); // R11
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
    import rcs_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFE01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_pwr_on,
    input  logic              evt_pin,
    input  logic              evt_wdog,
    input  logic              evt_bad_op,
    input  logic              evt_bad_addr,
    input  logic              evt_addr_fetch,
    input  logic              evt_mon_entry,
    input  logic              evt_vec_blank,
    input  logic              evt_low_volt,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] rd_data
);
    rst_evt_t          evt;
    bus_hit_t          hit;
    logic              pwr_on;
    logic [DATA_W-1:0] set_mask;
    logic [DATA_W-1:0] flags;

    assign evt = '{pwr_on:     evt_pwr_on,
                   pin:        evt_pin,
                   wdog:       evt_wdog,
                   bad_op:     evt_bad_op,
                   bad_addr:   evt_bad_addr,
                   addr_fetch: evt_addr_fetch,
                   mon_entry:  evt_mon_entry,
                   vec_blank:  evt_vec_blank,
                   low_volt:   evt_low_volt};

    rcs_bus_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_decode (
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .hit      (hit)
    );

    rcs_event_qual u_qual (
        .evt      (evt),
        .pwr_on   (pwr_on),
        .set_mask (set_mask)
    );

    rcs_cause_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .pwr_on   (pwr_on),
        .set_mask (set_mask),
        .rd_hit   (hit.rd_hit),
        .flags    (flags)
    );

    rcs_read_port u_rdport (
        .clk      (clk),
        .rst      (rst),
        .rd_hit   (hit.rd_hit),
        .flags    (flags),
        .rd_data  (rd_data)
    );

    AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (hit.wr_hit && (bus_wdata != '0) && !hit.rd_hit && !evt_pwr_on && !evt_pin &&
         !evt_wdog && !evt_bad_op && !evt_bad_addr && !evt_mon_entry && !evt_low_volt)
        |=> $stable(flags)); // R10

    AST_DATA_FETCH_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (evt_bad_addr && !evt_addr_fetch && !hit.rd_hit && !evt_pwr_on)
        |=> $stable(flags[POS_BADADDR])); // R5
endmodule

// File: tb/rst_cause_reg_test.sv
`timescale 1ns/1ps
module rst_cause_reg_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_pwr_on = 0, evt_pin = 0, evt_wdog = 0, evt_bad_op = 0;
    logic        evt_bad_addr = 0, evt_addr_fetch = 0, evt_mon_entry = 0;
    logic        evt_vec_blank = 0, evt_low_volt = 0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_rd = 0, bus_wr = 0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk; // 50 MHz

    rst_cause_reg uut (
        .clk(clk), .rst(rst),
        .evt_pwr_on(evt_pwr_on), .evt_pin(evt_pin), .evt_wdog(evt_wdog),
        .evt_bad_op(evt_bad_op), .evt_bad_addr(evt_bad_addr),
        .evt_addr_fetch(evt_addr_fetch), .evt_mon_entry(evt_mon_entry),
        .evt_vec_blank(evt_vec_blank), .evt_low_volt(evt_low_volt),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .rd_data(rd_data)
    );

    // Stimulus bits: [16]pwr_on [15]pin [14]wdog [13]bad_op [12]bad_addr
    // [11]addr_fetch [10]mon_entry [9]vec_blank [8]low_volt; [7:0] expected read.
    localparam int NVEC = 11;
    localparam logic [16:0] VEC [NVEC] = '{
        {9'b0_1000_0000, 8'h40},  // R4 pin
        {9'b0_0100_0000, 8'h20},  // R4 watchdog
        {9'b0_0010_0000, 8'h10},  // R4 illegal opcode
        {9'b0_0001_1000, 8'h08},  // R4 R5 illegal fetch
        {9'b0_0001_0000, 8'h00},  // R5 data access ignored
        {9'b0_0000_0110, 8'h04},  // R4 R6 monitor entry, blank vectors
        {9'b0_0000_0100, 8'h00},  // R6 monitor entry, vectors programmed
        {9'b0_0000_0001, 8'h02},  // R4 low voltage
        {9'b0_1000_0001, 8'h42},  // R7 same-cycle accumulation
        {9'b1_1000_0000, 8'h80},  // R8 power-on overrides pin
        {9'b0_1111_1111, 8'h7E}   // R7 every sticky source
    };
    localparam int VREQ [NVEC] = '{4, 4, 4, 4, 5, 4, 6, 4, 7, 8, 7};

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic drive_evt(input logic [8:0] s);
        {evt_pwr_on, evt_pin, evt_wdog, evt_bad_op, evt_bad_addr,
         evt_addr_fetch, evt_mon_entry, evt_vec_blank, evt_low_volt} = s;
    endtask

    task automatic pulse(input logic [8:0] s);
        @(negedge clk); drive_evt(s);
        @(negedge clk); drive_evt('0);
    endtask

    // Read; rd_data is valid at the negedge after the capturing posedge.
    task automatic do_read(input logic [15:0] a);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; bus_addr = 16'h0000;
        checks++;
        if (rd_data[0] !== 1'b0) begin
            errors++;
            $display("FAIL R11: bit0 got %b expected 0", rd_data[0]);
        end
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] prev;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R12 reset rd_data", rd_data, 8'h00);
        do_read(16'hFE01);
        check("R1 reset value", rd_data, 8'h80);
        do_read(16'hFE01);
        check("R3 cleared by read", rd_data, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            do_read(16'hFE01);
            pulse(VEC[i][16:8]);
            do_read(16'hFE01);
            check($sformatf("R%0d table entry %0d", VREQ[i], i), rd_data, VEC[i][7:0]);
        end

        // R7 accumulation across separate cycles
        do_read(16'hFE01);
        pulse(9'b0_1000_0000);
        pulse(9'b0_0100_0000);
        do_read(16'hFE01);
        check("R7 separate cycles", rd_data, 8'h60);

        // R2 wrong address neither reads nor clears
        pulse(9'b0_1000_0000);
        prev = rd_data;
        do_read(16'hFE00);
        check("R2 near address rd_data", rd_data, prev);
        do_read(16'hFF01);
        check("R2 far address rd_data", rd_data, prev);
        do_read(16'hFE01);
        check("R2 flags kept", rd_data, 8'h40);

        // R12 hold between reads
        repeat (3) @(negedge clk);
        check("R12 hold", rd_data, 8'h40);

        // R10 write has no effect
        pulse(9'b0_0000_0001);
        @(negedge clk); bus_addr = 16'hFE01; bus_wr = 1'b1; bus_wdata = 8'hFF;
        @(negedge clk); bus_wr = 1'b0; bus_wdata = 8'h00;
        do_read(16'hFE01);
        check("R10 write ignored", rd_data, 8'h02);

        // R9 event and read in the same cycle
        pulse(9'b0_1000_0000);
        @(negedge clk); bus_addr = 16'hFE01; bus_rd = 1'b1; drive_evt(9'b0_0100_0000);
        @(negedge clk); bus_rd = 1'b0; drive_evt('0);
        check("R9 read returns old flags", rd_data, 8'h40);
        do_read(16'hFE01);
        check("R9 new bit survives", rd_data, 8'h20);

        // R1 R8 power-on after other causes
        pulse(9'b0_0100_0001);
        pulse(9'b1_0000_0000);
        do_read(16'hFE01);
        check("R1 power-on event value", rd_data, 8'h80);

        // R8 power-on with a read in the same cycle
        @(negedge clk); bus_addr = 16'hFE01; bus_rd = 1'b1; drive_evt(9'b1_0010_0000);
        @(negedge clk); bus_rd = 1'b0; drive_evt('0);
        check("R8 read during power-on", rd_data, 8'h00);
        do_read(16'hFE01);
        check("R8 power-on wins over read", rd_data, 8'h80);

        // R1 synchronous reset reloads power-on value
        pulse(9'b0_0010_0000);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R12 rd_data after reset", rd_data, 8'h00);
        do_read(16'hFE01);
        check("R1 value after second reset", rd_data, 8'h80);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule